// File: doc/BRIEF.md
# Closed-Page Posted-Column Command Scheduler

This block issues DRAM commands for a closed-page memory device that uses posted column commands (an additive latency inside the device). Each request handed to it carries a direction (read or write), a rank, a bank, a row and a column. For every accepted request the block puts a row-activate command on the command bus, and in the very next clock a column command that always closes the row again through auto-precharge. Because the column command is posted, the block never waits out the activate-to-column delay on the command bus.

Spacing between requests is set by the shared data bus and not by command-bus collisions. The block keeps the cycle of the last column command with its direction and rank. It holds off a new request until that request's data burst can neither overlap the previous burst nor break a read/write turnaround or a rank handoff rule. While it holds off, the command bus carries NOP. Alongside the commands it drives a per-cycle prediction of data-bus occupancy: whether the bus is busy, in which direction, and for which rank. A counter reports how many requests have been taken.

Top module: `posted_cas_sched`

## Requirements
- R1: A request taken on a clock edge (reqValid and reqReady both high) puts an activate (cmdOp = 1) on the bus in the next cycle and its column command in the cycle after that. Only one command is driven per clock, and every other cycle carries NOP (cmdOp = 0).
- R2: The column command is read-with-auto-precharge (cmdOp = 2) or write-with-auto-precharge (cmdOp = 3). It carries the same rank and bank as its activate. cmdAddr holds the row during an activate, the column during a column command, and zero during NOP, as do cmdBank and cmdRank.
- R3: For a read, busValid is high with busWrite low for BURST cycles, starting AL + CL cycles after the column command. busRank gives the request's rank.
- R4: For a write, the same occupancy starts AL + CL − 1 cycles after the column command, with busWrite high.
- R5: Two reads to one rank, or two writes, may have column commands as close as BURST cycles apart.
- R6: A read that follows a read to a different rank has its column command at least BURST + 1 cycles after the earlier one, which leaves one idle handoff cycle on the data bus.
- R7: A write that follows a read has its column command at least BURST + 1 cycles after the read's.
- R8: A read that follows a write has its column command at least CL + BURST − 1 + TWTR cycles after the write's. With BURST = 2 this is CL + 1 + TWTR.
- R9: reqReady is low in any cycle whose command is an activate. Otherwise it is high exactly when the presented request meets R5 to R8 against the last column command. A request held off this way sees NOP cycles until it is taken.
- R10: acceptCount rises by one in the cycle after each handshake. A request presented while reqReady is low leaves the count and the command bus untouched.
- R11: During reset the outputs are NOP with zero address, bank and rank, the bus is idle, and the count is zero. The first request after reset is ready at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRank | input | RANK_W | Target rank (device on the shared bus) |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ROW_W | Row address |
| reqCol | input | COL_W | Column address |
| reqReady | output | 1 | Request can be taken this cycle |
| cmdOp | output | 2 | 0 NOP, 1 activate, 2 read+AP, 3 write+AP |
| cmdRank | output | RANK_W | Rank of the current command |
| cmdBank | output | BANK_W | Bank of the current command |
| cmdAddr | output | ADDR_W | Row or column of the current command |
| busValid | output | 1 | Data bus predicted busy this cycle |
| busWrite | output | 1 | Predicted burst is write data |
| busRank | output | RANK_W | Rank owning the predicted burst |
| acceptCount | output | CNT_W | Number of requests taken |

## Verification
The activate is due one cycle after a handshake and the column command two cycles after it. Data occupancy starts AL + CL cycles (read) or AL + CL − 1 cycles (write) after that column command, and the counter moves one cycle after the handshake. The bench numbers every clock after reset. When its model takes a request in cycle t, it books the activate at t + 1, the column command at t + 2 and the burst cycles after that in tables keyed by cycle number. Every cycle it compares all outputs half a period after the edge with whatever its tables hold for that cycle. reqReady is checked in the same cycle against the spacing rule that applies to the request being presented.

// File: rtl/posted_cas_sched_pkg.sv
package posted_cas_sched_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_RDAP = 2'd2,
    CMD_WRAP = 2'd3
  } cmdOp_t;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic accept;    // request handshake this cycle
    logic issueCol;  // column command goes out next cycle
    logic colWrite;  // direction of that column command
  } schedStrobe_t;

endpackage

// File: rtl/posted_cas_sched_ctrl.sv
module posted_cas_sched_ctrl
  import posted_cas_sched_pkg::*;
#(
  parameter int RANK_W = 1,
  parameter int AL     = 2,
  parameter int CL     = 2,
  parameter int BURST  = 2,
  parameter int TWTR   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [RANK_W-1:0] reqRank,
  output logic              reqReady,
  output schedStrobe_t      strobe
);

  localparam int RL       = AL + CL;
  localparam int WL       = RL - 1;
  localparam int GAP_SAME = BURST;
  localparam int GAP_HAND = BURST + 1;
  localparam int GAP_RW   = RL - WL + BURST;
  localparam int GAP_WR   = WL + BURST + TWTR - AL;
  localparam int GAP_M1   = (GAP_WR > GAP_RW) ? GAP_WR : GAP_RW;
  localparam int GAP_MAX  = (GAP_M1 > GAP_HAND) ? GAP_M1 : GAP_HAND;
  localparam int CW       = $clog2(GAP_MAX + 2) + 1;
  localparam logic [CW:0] LEAD = (CW+1)'(2);  // accept-to-column distance

  logic              actPending;
  logic [CW-1:0]     colCnt;      // cycles since the last column command
  logic              lastWrite;
  logic [RANK_W-1:0] lastRank;
  logic [CW-1:0]     gapNeed;
  logic              spacingOk;
  logic              accept;

  always_comb begin
    if (lastWrite && !reqWrite)
      gapNeed = CW'(GAP_WR);
    else if (!lastWrite && reqWrite)
      gapNeed = CW'(GAP_RW);
    else if (!lastWrite && (reqRank != lastRank))
      gapNeed = CW'(GAP_HAND);
    else
      gapNeed = CW'(GAP_SAME);
  end

  assign spacingOk = ({1'b0, colCnt} + LEAD) >= {1'b0, gapNeed};
  assign reqReady  = !actPending && spacingOk;
  assign accept    = reqValid && reqReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actPending <= 1'b0;
      colCnt     <= '1;
      lastWrite  <= 1'b0;
      lastRank   <= '0;
    end else begin
      actPending <= accept;
      if (accept) begin
        lastWrite <= reqWrite;
        lastRank  <= reqRank;
      end
      if (actPending)
        colCnt <= '0;
      else if (colCnt != '1)
        colCnt <= colCnt + CW'(1);
    end
  end

  assign strobe.accept   = accept;
  assign strobe.issueCol = actPending;
  assign strobe.colWrite = lastWrite;

endmodule

// File: rtl/posted_cas_sched_dp.sv
module posted_cas_sched_dp
  import posted_cas_sched_pkg::*;
#(
  parameter int RANK_W = 1,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 14,
  parameter int AL     = 2,
  parameter int CL     = 2,
  parameter int BURST  = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  schedStrobe_t      strobe,
  input  logic [RANK_W-1:0] reqRank,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic [1:0]        cmdOp,
  output logic [RANK_W-1:0] cmdRank,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              busValid,
  output logic              busWrite,
  output logic [RANK_W-1:0] busRank,
  output logic [CNT_W-1:0]  acceptCount
);

  localparam int RL    = AL + CL;
  localparam int WL    = RL - 1;
  localparam int DEPTH = RL + BURST;

  cmdOp_t            opQ;
  logic [RANK_W-1:0] pendRank;
  logic [BANK_W-1:0] pendBank;
  logic [COL_W-1:0]  pendCol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opQ         <= CMD_NOP;
      cmdRank     <= '0;
      cmdBank     <= '0;
      cmdAddr     <= '0;
      pendRank    <= '0;
      pendBank    <= '0;
      pendCol     <= '0;
      acceptCount <= '0;
    end else begin
      if (strobe.accept) begin
        opQ         <= CMD_ACT;
        cmdRank     <= reqRank;
        cmdBank     <= reqBank;
        cmdAddr     <= ADDR_W'(reqRow);
        pendRank    <= reqRank;
        pendBank    <= reqBank;
        pendCol     <= reqCol;
        acceptCount <= acceptCount + CNT_W'(1);
      end else if (strobe.issueCol) begin
        opQ     <= strobe.colWrite ? CMD_WRAP : CMD_RDAP;
        cmdRank <= pendRank;
        cmdBank <= pendBank;
        cmdAddr <= ADDR_W'(pendCol);
      end else begin
        opQ     <= CMD_NOP;
        cmdRank <= '0;
        cmdBank <= '0;
        cmdAddr <= '0;
      end
    end
  end

  assign cmdOp = opQ;

  // Occupancy delay line: slot g describes the cycle g clocks ahead
  logic              occV [DEPTH];
  logic              occW [DEPTH];
  logic [RANK_W-1:0] occR [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam bit RD_HIT = (g >= RL) && (g < RL + BURST);
    localparam bit WR_HIT = (g >= WL) && (g < WL + BURST);
    logic              shV;
    logic              shW;
    logic [RANK_W-1:0] shR;
    logic              hit;

    if (g == DEPTH - 1) begin : g_top
      assign shV = 1'b0;
      assign shW = 1'b0;
      assign shR = '0;
    end else begin : g_mid
      assign shV = occV[g+1];
      assign shW = occW[g+1];
      assign shR = occR[g+1];
    end

    assign hit = strobe.issueCol && (strobe.colWrite ? WR_HIT : RD_HIT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occV[g] <= 1'b0;
        occW[g] <= 1'b0;
        occR[g] <= '0;
      end else if (hit) begin
        occV[g] <= 1'b1;
        occW[g] <= strobe.colWrite;
        occR[g] <= pendRank;
      end else begin
        occV[g] <= shV;
        occW[g] <= shW;
        occR[g] <= shR;
      end
    end
  end

  assign busValid = occV[0];
  assign busWrite = occW[0];
  assign busRank  = occR[0];

endmodule

// File: rtl/posted_cas_sched.sv
module posted_cas_sched
  import posted_cas_sched_pkg::*;
#(
  parameter int RANK_W = 1,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  parameter int AL     = 2,
  parameter int CL     = 2,
  parameter int BURST  = 2,
  parameter int TWTR   = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [RANK_W-1:0] reqRank,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic              reqReady,
  output logic [1:0]        cmdOp,
  output logic [RANK_W-1:0] cmdRank,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              busValid,
  output logic              busWrite,
  output logic [RANK_W-1:0] busRank,
  output logic [CNT_W-1:0]  acceptCount
);

  schedStrobe_t strobe;

  posted_cas_sched_ctrl #(
    .RANK_W(RANK_W), .AL(AL), .CL(CL), .BURST(BURST), .TWTR(TWTR)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqRank  (reqRank),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  posted_cas_sched_dp #(
    .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .ADDR_W(ADDR_W), .AL(AL), .CL(CL), .BURST(BURST), .CNT_W(CNT_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .reqRank     (reqRank),
    .reqBank     (reqBank),
    .reqRow      (reqRow),
    .reqCol      (reqCol),
    .cmdOp       (cmdOp),
    .cmdRank     (cmdRank),
    .cmdBank     (cmdBank),
    .cmdAddr     (cmdAddr),
    .busValid    (busValid),
    .busWrite    (busWrite),
    .busRank     (busRank),
    .acceptCount (acceptCount)
  );

endmodule

// File: rtl/posted_cas_sched_checker.sv
module posted_cas_sched_checker #(
  parameter int RANK_W = 1,
  parameter int BANK_W = 3,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        cmdOp,
  input logic [RANK_W-1:0] cmdRank,
  input logic [BANK_W-1:0] cmdBank,
  input logic [CNT_W-1:0]  acceptCount
);

  a_r1_act_then_col: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdOp == 2'd1) |=> cmdOp[1]);

  a_r1_col_after_act: assert property (@(posedge clk) disable iff (!rst_n)
    cmdOp[1] |-> ($past(cmdOp) == 2'd1));

  a_r2_same_bank: assert property (@(posedge clk) disable iff (!rst_n)
    cmdOp[1] |-> (cmdBank == $past(cmdBank) && cmdRank == $past(cmdRank)));

  a_r9_no_ready_on_act: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdOp == 2'd1) |-> !reqReady);

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> (acceptCount == $past(acceptCount) + CNT_W'(1)));

  a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reqValid && reqReady) |=> $stable(acceptCount));

endmodule

bind posted_cas_sched posted_cas_sched_checker #(
  .RANK_W(RANK_W), .BANK_W(BANK_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .cmdOp       (cmdOp),
  .cmdRank     (cmdRank),
  .cmdBank     (cmdBank),
  .acceptCount (acceptCount)
);

// File: tb/posted_cas_sched_test.sv
module posted_cas_sched_test;

  localparam int RANK_W = 1;
  localparam int BANK_W = 3;
  localparam int ROW_W  = 14;
  localparam int COL_W  = 10;
  localparam int ADDR_W = 14;
  localparam int AL     = 2;
  localparam int CL     = 2;
  localparam int BURST  = 2;
  localparam int TWTR   = 2;
  localparam int CNT_W  = 16;
  localparam int RL     = AL + CL;
  localparam int WL     = RL - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              reqValid;
  logic              reqWrite;
  logic [RANK_W-1:0] reqRank;
  logic [BANK_W-1:0] reqBank;
  logic [ROW_W-1:0]  reqRow;
  logic [COL_W-1:0]  reqCol;
  logic              reqReady;
  logic [1:0]        cmdOp;
  logic [RANK_W-1:0] cmdRank;
  logic [BANK_W-1:0] cmdBank;
  logic [ADDR_W-1:0] cmdAddr;
  logic              busValid;
  logic              busWrite;
  logic [RANK_W-1:0] busRank;
  logic [CNT_W-1:0]  acceptCount;

  posted_cas_sched uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqRank(reqRank), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqReady(reqReady), .cmdOp(cmdOp), .cmdRank(cmdRank), .cmdBank(cmdBank),
    .cmdAddr(cmdAddr), .busValid(busValid), .busWrite(busWrite),
    .busRank(busRank), .acceptCount(acceptCount)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  reported = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  typedef struct {
    bit w;
    int rank;
    int bank;
    int row;
    int col;
    int idle;
  } stim_t;

  stim_t q[$];

  task automatic add(bit w, int rank, int bank, int row, int col, int idle);
    stim_t s;
    s.w = w; s.rank = rank; s.bank = bank; s.row = row; s.col = col; s.idle = idle;
    q.push_back(s);
  endtask

  // Expected values keyed by cycle number
  int expOp[int];
  int expAddr[int];
  int expBank[int];
  int expRank[int];
  int expBV[int];
  int expBW[int];
  int expBR[int];

  function automatic int gapOf(bit pw, int pr, bit w, int r);
    if (pw && !w)             return CL + BURST - 1 + TWTR;
    if (!pw && w)             return BURST + 1;
    if (!pw && !w && pr != r) return BURST + 1;
    return BURST;
  endfunction

  function automatic string gapTag(bit pw, int pr, bit w, int r);
    if (pw && !w)             return "R8";
    if (!pw && w)             return "R7";
    if (!pw && !w && pr != r) return "R6";
    return "R5";
  endfunction

  initial begin
    #(5ns * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int  t;
    int  lastCol;
    bit  lastW;
    int  lastRk;
    bit  hist;
    int  expCnt;
    int  idleLeft;
    bit  expReady;
    int  op;
    string tag;

    rst_n = 1'b0;
    reqValid = 1'b0; reqWrite = 1'b0; reqRank = '0; reqBank = '0; reqRow = '0; reqCol = '0;

    add(0, 0, 0, 14'h0123, 10'h010, 0);
    add(0, 0, 1, 14'h02A5, 10'h020, 0);  // R5 read-read same rank
    add(0, 0, 2, 14'h1F00, 10'h3FF, 0);
    add(0, 1, 3, 14'h0777, 10'h001, 0);  // R6 rank handoff
    add(1, 1, 4, 14'h3FFF, 10'h155, 0);  // R7 read to write
    add(1, 0, 5, 14'h0042, 10'h2AA, 0);  // R5 write-write
    add(0, 0, 6, 14'h0808, 10'h0F0, 0);  // R8 write to read
    add(0, 0, 7, 14'h1234, 10'h00F, 1);  // one-cycle stall
    add(1, 1, 0, 14'h0505, 10'h100, 3);
    add(0, 1, 1, 14'h2222, 10'h0AA, 0);  // R8 same rank
    add(0, 0, 2, 14'h0001, 10'h002, 6);
    add(1, 0, 3, 14'h3000, 10'h300, 0);
    add(0, 1, 4, 14'h0C0C, 10'h0C0, 0);  // R8 across ranks
    add(1, 1, 5, 14'h1111, 10'h111, 10);
    add(1, 1, 6, 14'h2468, 10'h246, 0);

    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk("R11", "reqReady", reqReady, 1);
    chk("R11", "cmdOp", cmdOp, 0);
    chk("R11", "cmdAddr", cmdAddr, 0);
    chk("R11", "busValid", busValid, 0);
    chk("R11", "acceptCount", acceptCount, 0);
    rst_n = 1'b1;

    t = 0; lastCol = -100; lastW = 0; lastRk = 0; hist = 0; expCnt = 0;
    idleLeft = q[0].idle;

    for (int iter = 0; iter < 3000; iter++) begin
      if (q.size() > 0 && idleLeft == 0) begin
        reqValid = 1'b1;
        reqWrite = q[0].w;
        reqRank  = RANK_W'(q[0].rank);
        reqBank  = BANK_W'(q[0].bank);
        reqRow   = ROW_W'(q[0].row);
        reqCol   = COL_W'(q[0].col);
      end else begin
        reqValid = 1'b0; reqWrite = 1'b0; reqRank = '0; reqBank = '0; reqRow = '0; reqCol = '0;
      end
      #1;

      op = expOp.exists(t) ? expOp[t] : 0;
      expReady = (op != 1) &&
                 (!hist || (t + 2 - lastCol) >= gapOf(lastW, lastRk, reqWrite, int'(reqRank)));
      if (op == 1 || !hist) tag = "R9";
      else tag = gapTag(lastW, lastRk, reqWrite, int'(reqRank));
      chk(tag, "reqReady", reqReady, expReady);

      chk("R1", "cmdOp", cmdOp, op);
      chk("R2", "cmdAddr", cmdAddr, expAddr.exists(t) ? expAddr[t] : 0);
      chk("R2", "cmdBank", cmdBank, expBank.exists(t) ? expBank[t] : 0);
      chk("R2", "cmdRank", cmdRank, expRank.exists(t) ? expRank[t] : 0);

      tag = (expBW.exists(t) && expBW[t] == 1) ? "R4" : "R3";
      chk(tag, "busValid", busValid, expBV.exists(t) ? expBV[t] : 0);
      chk(tag, "busWrite", busWrite, expBW.exists(t) ? expBW[t] : 0);
      chk(tag, "busRank", busRank, expBR.exists(t) ? expBR[t] : 0);

      chk("R10", "acceptCount", acceptCount, expCnt);

      if (reqValid && expReady) begin
        int lat;
        expOp[t+1]   = 1;
        expAddr[t+1] = q[0].row;
        expBank[t+1] = q[0].bank;
        expRank[t+1] = q[0].rank;
        expOp[t+2]   = q[0].w ? 3 : 2;
        expAddr[t+2] = q[0].col;
        expBank[t+2] = q[0].bank;
        expRank[t+2] = q[0].rank;
        lat = q[0].w ? WL : RL;
        for (int k = 0; k < BURST; k++) begin
          expBV[t+2+lat+k] = 1;
          expBW[t+2+lat+k] = q[0].w;
          expBR[t+2+lat+k] = q[0].rank;
        end
        lastCol = t + 2;
        lastW   = q[0].w;
        lastRk  = q[0].rank;
        hist    = 1;
        expCnt++;
        void'(q.pop_front());
        idleLeft = (q.size() > 0) ? q[0].idle : 0;
      end else if (!reqValid && idleLeft > 0) begin
        idleLeft--;
      end

      if (q.size() == 0 && t > lastCol + RL + BURST + 4) break;
      t++;
      @(negedge clk);
    end

    if (q.size() != 0) begin
      nChecks++;
      nFails++;
      $display("FAIL R9 requests left: actual %0d expected 0", q.size());
    end
    report();
  end

endmodule